// File: doc/BRIEF.md
# Iterative CORDIC Sine/Cosine Oscillator

This block is a low-area digital oscillator. A phase accumulator advances by a programmable increment once per output sample. An optional phase offset word is added to the accumulated phase for that sample only. The top bits of the resulting angle are rotated into sine and cosine by a single shift-and-add rotation stage. That stage is reused for `MAG_W` consecutive enabled clocks, so one sample of both waveforms comes out every `MAG_W` enabled cycles.

Before the iterations, a coarse step rotates the starting vector by a whole multiple of a quarter turn. The iterations therefore only have to resolve a residual angle of at most an eighth of a turn. The starting vector already carries the inverse of the rotation gain, so no multiplier is needed after the iterations. The final values are rounded and clipped to a symmetric range before they reach the output registers.

The output side is a plain strobe and has no back-pressure. `out_valid` is high for exactly one clock per sample, and a consumer must capture `sine` and `cosine` in that cycle. The buses then hold their value until the next strobe. On the input side, `phase_inc` and `phase_mod` are sampled together once per sample period, on the last enabled cycle of the iteration sequence. Between those cycles their values are ignored. `clken` freezes every register of the block; while it is low no strobe can be produced.

Top module: `cordic_serial_osc`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `sine` and `cosine` are 0.
- R2: `out_valid` is never high in two consecutive clocks. Two consecutive pulses are set by enabled edges exactly `MAG_W` enabled edges apart.
- R3: The first pulse after reset is set by the (2·MAG_W+1)-th enabled rising edge, so it is seen in the (2·MAG_W+2)-th enabled cycle.
- R4: At each pulse, `sine` is within 5 LSB of A·sin θ and `cosine` is within 5 LSB of A·cos θ. Here A = 2^(MAG_W−1)−1 and θ = 2π·φ/2^PHASE_W, where φ is the sample's phase in two's-complement-free unsigned turns.
- R5: The sample phase φ is the accumulator plus the offset, and the accumulator then advances by `phase_inc` once per sample. Sample 1 therefore uses an accumulator of 0, and sample k uses the sum of the increments taken with samples 1..k−1.
- R6: `phase_mod` (PM_W bits) is placed in the top bits of the phase, so it is weighted by 2^(PHASE_W−PM_W). It shifts only the sample it is taken with and never enters the accumulator.
- R7: Input values present on cycles other than the sampling cycle have no effect on any output.
- R8: While `clken` is low, no state advances. A low `clken` at an edge forces `out_valid` low after that edge. The sequence of output samples is the same as with `clken` held high.
- R9: The accumulator and the phase sum wrap modulo 2^PHASE_W, so increments near 2^PHASE_W act as negative frequencies.
- R10: `sine` and `cosine` are clipped to ±A and never take the value −2^(MAG_W−1).
- R11: `sine` and `cosine` change only in the clocks where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clken | input | 1 | Clock enable; low freezes all state |
| phase_inc | input | PHASE_W | Phase step added to the accumulator once per sample |
| phase_mod | input | PM_W | Phase offset for the current sample, weighted into the top bits |
| sine | output | MAG_W | Signed sine sample |
| cosine | output | MAG_W | Signed cosine sample |
| out_valid | output | 1 | One-clock strobe marking a new sample |

## Verification
Two things happen on the same enabled edge. The finished vector of one sample is published to the output registers, and the pre-rotated angle of the next sample is loaded into the shared rotation stage. The bench provokes this in every period by running a different phase each period, at first with `clken` held high and then with `clken` dropped on a repeating pattern that also lands on that edge. Each published sample is judged against a reference computed from its own accumulated phase and offset, so a result mixed with the next sample's angle shows up as a value error. A drift in pulse spacing or latency also shows up as an error.

// File: rtl/sco_pkg.sv
package sco_pkg;
  // coarse quarter-turn selection applied before the fine iterations
  typedef enum logic [1:0] {
    QUAD_0   = 2'd0,
    QUAD_90  = 2'd1,
    QUAD_180 = 2'd2,
    QUAD_270 = 2'd3
  } quad_e;

  localparam real TWO_PI   = 6.283185307179586;
  // reciprocal of the accumulated rotation gain of the shift-add iterations
  localparam real INV_GAIN = 0.6072529350088813;
endpackage

// File: rtl/sco_iter_ctrl.sv
module sco_iter_ctrl #(
  parameter int ITER  = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clken,
  output logic [IDX_W-1:0] iter_idx,
  output logic             take_inputs,
  output logic             load_angle,
  output logic             result_live
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ITER - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             ph_ok_q;
  logic             eng_ok_q;

  assign iter_idx    = cnt_q;
  assign take_inputs = clken && (cnt_q == LAST);
  assign load_angle  = clken && (cnt_q == '0);
  assign result_live = eng_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ph_ok_q  <= 1'b0;
      eng_ok_q <= 1'b0;
    end else begin
      if (clken) begin
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      // first real phase is captured at the end of the first period
      if (take_inputs) begin
        ph_ok_q <= 1'b1;
      end
      // the rotation stage holds a real sample once it loads a captured phase
      if (load_angle) begin
        eng_ok_q <= ph_ok_q;
      end
    end
  end
endmodule

// File: rtl/sco_phase_front.sv
module sco_phase_front
  import sco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int PM_W    = 16,
  parameter int ANG_W   = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [PHASE_W-1:0]      inc,
  input  logic [PM_W-1:0]         pm,
  output quad_e                   quad,
  output logic signed [ANG_W-1:0] resid
);
  localparam logic [ANG_W-1:0] EIGHTH = ANG_W'(1) << (ANG_W - 3);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] ph_q;
  logic [PHASE_W-1:0] pm_ext;
  logic [ANG_W-1:0]   angle;
  logic [ANG_W-1:0]   rounded;
  logic [ANG_W-1:0]   base;

  assign pm_ext = PHASE_W'(pm) << (PHASE_W - PM_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ph_q  <= '0;
    end else if (take) begin
      ph_q  <= acc_q + pm_ext;
      acc_q <= acc_q + inc;
    end
  end

  // nearest quarter turn, leaving a residual in [-1/8, +1/8) turn
  always_comb begin
    angle   = ph_q[PHASE_W-1 -: ANG_W];
    rounded = angle + EIGHTH;
    quad    = quad_e'(rounded[ANG_W-1 -: 2]);
    base    = {rounded[ANG_W-1 -: 2], {(ANG_W-2){1'b0}}};
    resid   = signed'(angle - base);
  end
endmodule

// File: rtl/sco_atan_table.sv
module sco_atan_table
  import sco_pkg::*;
#(
  parameter int ITER  = 16,
  parameter int ANG_W = 18,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx,
  output logic [ANG_W-1:0] step_angle
);
  logic [ANG_W-1:0] tbl [ITER];

  // entry i: arctangent of 2^-i, in units of one turn / 2^ANG_W
  for (genvar i = 0; i < ITER; i++) begin : g_ent
    localparam real RAD = $atan(1.0 / (2.0 ** i));
    localparam int  VAL = $rtoi(RAD / TWO_PI * (2.0 ** ANG_W) + 0.5);
    assign tbl[i] = ANG_W'(VAL);
  end

  always_comb begin
    step_angle = '0;
    for (int k = 0; k < ITER; k++) begin
      if (idx == IDX_W'(k)) begin
        step_angle = tbl[k];
      end
    end
  end
endmodule

// File: rtl/sco_rotator.sv
module sco_rotator
  import sco_pkg::*;
#(
  parameter int ANG_W  = 18,
  parameter int INT_W  = 21,
  parameter int IDX_W  = 4,
  parameter int X_INIT = 318976
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clken,
  input  logic                    load,
  input  logic [IDX_W-1:0]        idx,
  input  quad_e                   quad,
  input  logic signed [ANG_W-1:0] resid,
  input  logic [ANG_W-1:0]        step_angle,
  output logic signed [INT_W-1:0] x_o,
  output logic signed [INT_W-1:0] y_o
);
  localparam logic signed [INT_W-1:0] X0 = INT_W'(X_INIT);

  logic signed [INT_W-1:0] x_q, y_q;
  logic signed [ANG_W-1:0] z_q;
  logic signed [INT_W-1:0] xi, yi, xs, ys, xn, yn;
  logic signed [ANG_W-1:0] zi, zn, st;
  logic                    pos;

  always_comb begin
    if (load) begin
      zi = resid;
      unique case (quad)
        QUAD_0:   begin xi = X0;  yi = '0;  end
        QUAD_90:  begin xi = '0;  yi = X0;  end
        QUAD_180: begin xi = -X0; yi = '0;  end
        default:  begin xi = '0;  yi = -X0; end
      endcase
    end else begin
      xi = x_q;
      yi = y_q;
      zi = z_q;
    end
    st  = signed'(step_angle);
    pos = ~zi[ANG_W-1];
    xs  = xi >>> idx;
    ys  = yi >>> idx;
    if (pos) begin
      xn = xi - ys;
      yn = yi + xs;
      zn = zi - st;
    end else begin
      xn = xi + ys;
      yn = yi - xs;
      zn = zi + st;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else if (clken) begin
      x_q <= xn;
      y_q <= yn;
      z_q <= zn;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;
endmodule

// File: rtl/cordic_serial_osc.sv
module cordic_serial_osc
  import sco_pkg::*;
#(
  parameter int MAG_W   = 16,
  parameter int PHASE_W = 32,
  parameter int PM_W    = 16,
  parameter int GUARD   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clken,
  input  logic [PHASE_W-1:0]      phase_inc,
  input  logic [PM_W-1:0]         phase_mod,
  output logic signed [MAG_W-1:0] sine,
  output logic signed [MAG_W-1:0] cosine,
  output logic                    out_valid
);
  localparam int ANG_W  = MAG_W + 2;
  localparam int INT_W  = MAG_W + GUARD + 1;
  localparam int IDX_W  = (MAG_W > 1) ? $clog2(MAG_W) : 1;
  localparam int AMP    = (2 ** (MAG_W - 1)) - 1;
  localparam int X_INIT = $rtoi(INV_GAIN * real'(AMP) * (2.0 ** GUARD) + 0.5);

  localparam logic signed [INT_W:0] AMP_X  = (INT_W+1)'(AMP);
  localparam logic signed [INT_W:0] NAMP_X = -AMP_X;
  localparam logic signed [INT_W:0] HALF_X = (INT_W+1)'(2 ** (GUARD - 1));

  logic [IDX_W-1:0]        iter_idx;
  logic                    take_inputs, load_angle, result_live;
  quad_e                   quad;
  logic signed [ANG_W-1:0] resid;
  logic [ANG_W-1:0]        step_angle;
  logic signed [INT_W-1:0] x_fin, y_fin;
  logic                    publish;

  sco_iter_ctrl #(.ITER(MAG_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clken(clken),
    .iter_idx(iter_idx), .take_inputs(take_inputs),
    .load_angle(load_angle), .result_live(result_live)
  );

  sco_phase_front #(.PHASE_W(PHASE_W), .PM_W(PM_W), .ANG_W(ANG_W)) u_front (
    .clk(clk), .rst_n(rst_n), .take(take_inputs),
    .inc(phase_inc), .pm(phase_mod), .quad(quad), .resid(resid)
  );

  sco_atan_table #(.ITER(MAG_W), .ANG_W(ANG_W), .IDX_W(IDX_W)) u_table (
    .idx(iter_idx), .step_angle(step_angle)
  );

  sco_rotator #(.ANG_W(ANG_W), .INT_W(INT_W), .IDX_W(IDX_W), .X_INIT(X_INIT)) u_rot (
    .clk(clk), .rst_n(rst_n), .clken(clken), .load(load_angle),
    .idx(iter_idx), .quad(quad), .resid(resid), .step_angle(step_angle),
    .x_o(x_fin), .y_o(y_fin)
  );

  // drop guard bits with rounding, then clip to the symmetric range
  function automatic logic signed [MAG_W-1:0] shape(input logic signed [INT_W-1:0] v);
    logic signed [INT_W:0] r;
    r = {v[INT_W-1], v} + HALF_X;
    r = r >>> GUARD;
    if (r > AMP_X) begin
      r = AMP_X;
    end else if (r < NAMP_X) begin
      r = NAMP_X;
    end
    return MAG_W'(r);
  endfunction

  // the edge that loads the next angle is the one after the last iteration
  assign publish = load_angle && result_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sine      <= '0;
      cosine    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= publish;
      if (publish) begin
        sine   <= shape(y_fin);
        cosine <= shape(x_fin);
      end
    end
  end
endmodule

// File: rtl/sco_checker.sv
module sco_checker #(
  parameter int MAG_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clken,
  input logic                    out_valid,
  input logic signed [MAG_W-1:0] sine,
  input logic signed [MAG_W-1:0] cosine
);
  localparam logic signed [MAG_W-1:0] MOST_NEG = {1'b1, {(MAG_W-1){1'b0}}};

  int unsigned en_edges;
  int unsigned gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_edges <= 0;
      gap      <= 0;
      seen     <= 1'b0;
    end else begin
      if (clken && en_edges < 32'h0000_FFFF) en_edges <= en_edges + 1;
      if (out_valid) begin
        seen <= 1'b1;
        gap  <= clken ? 1 : 0;
      end else if (clken && gap < 32'h0000_FFFF) begin
        gap <= gap + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r1: assert (!out_valid && sine == '0 && cosine == '0)
        else $error("outputs not cleared during reset");
    end
  end

  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen) |-> gap == MAG_W);

  p_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !seen) |-> en_edges == 2 * MAG_W + 1);

  p_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clken |=> !out_valid);

  p_no_most_neg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sine != MOST_NEG && cosine != MOST_NEG));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(sine) && $stable(cosine)));
endmodule

bind cordic_serial_osc sco_checker #(.MAG_W(MAG_W)) u_sco_checker (
  .clk(clk), .rst_n(rst_n), .clken(clken), .out_valid(out_valid),
  .sine(sine), .cosine(cosine)
);

// File: tb/cordic_serial_osc_bench.sv
module cordic_serial_osc_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  MAG_W      = 16;
  localparam int  PHASE_W    = 32;
  localparam int  PM_W       = 16;
  localparam int  NSTIM      = 32;
  localparam int  NSAMP      = NSTIM + 1;
  localparam real TOL        = 5.0;
  localparam real AMP        = 32767.0;
  localparam real TWO_PI     = 6.283185307179586;
  localparam int  WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clken = 1'b0;
  logic [PHASE_W-1:0] phase_inc = '0;
  logic [PM_W-1:0]    phase_mod = '0;
  logic signed [MAG_W-1:0] sine, cosine;
  logic out_valid;

  cordic_serial_osc #(.MAG_W(MAG_W), .PHASE_W(PHASE_W), .PM_W(PM_W)) u_cordic_serial_osc (
    .clk(clk), .rst_n(rst_n), .clken(clken), .phase_inc(phase_inc),
    .phase_mod(phase_mod), .sine(sine), .cosine(cosine), .out_valid(out_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    real   es;
    real   ec;
    string tag;
  } exp_t;

  exp_t               sb[$];
  logic [PHASE_W-1:0] stim_inc [NSTIM];
  logic [PM_W-1:0]    stim_pm  [NSTIM];
  string              stim_tag [NSTIM];
  logic [PHASE_W-1:0] model_acc;
  int total = 0;
  int bad = 0;

  task automatic check_int(input string tag, input string what, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic check_near(input string tag, input string what, input int act, input real expv);
    real d;
    total++;
    d = real'(act) - expv;
    if (d > TOL || d < -TOL) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0.2f", tag, what, act, expv);
    end
  endtask

  // reference: phase = accumulator + weighted offset, then accumulator steps
  task automatic push_expect(input int k);
    logic [PHASE_W-1:0] ph;
    real th;
    exp_t e;
    ph    = model_acc + (PHASE_W'(stim_pm[k]) << (PHASE_W - PM_W));
    th    = TWO_PI * real'(ph) / (2.0 ** PHASE_W);
    e.es  = AMP * $sin(th);
    e.ec  = AMP * $cos(th);
    e.tag = stim_tag[k];
    sb.push_back(e);
    model_acc = model_acc + stim_inc[k];
  endtask

  task automatic drive(input int k);
    phase_inc = stim_inc[k];
    phase_mod = stim_pm[k];
    push_expect(k);
  endtask

  initial begin
    int cyc = 0;
    int en_edges = 0;
    int last_en = 0;
    int pulses = 0;
    int junk_left = 0;
    int pend_k = 0;
    logic clk_was_en;
    logic signed [MAG_W-1:0] last_s, last_c;
    exp_t e;

    for (int k = 0; k < NSTIM; k++) begin
      if (k < 7) begin
        stim_inc[k] = 32'h0713_5C2B; stim_pm[k] = '0; stim_tag[k] = "R5";
      end else if (k < 14) begin
        stim_inc[k] = 32'h0100_0000; stim_pm[k] = PM_W'(k * 16'h2345); stim_tag[k] = "R6";
      end else if (k < 21) begin
        stim_inc[k] = 32'h1A2B_3C4D; stim_pm[k] = 16'h4000; stim_tag[k] = "R7";
      end else if (k < 25) begin
        stim_inc[k] = 32'hF3C0_0000; stim_pm[k] = '0; stim_tag[k] = "R9";
      end else begin
        stim_inc[k] = 32'h2000_0000; stim_pm[k] = 16'h1000; stim_tag[k] = "R8";
      end
    end

    repeat (4) @(negedge clk);
    check_int("R1", "out_valid in reset", longint'(out_valid), 0);
    check_int("R1", "sine in reset", longint'(sine), 0);
    check_int("R1", "cosine in reset", longint'(cosine), 0);

    model_acc = '0;
    drive(0);        // sample 1
    push_expect(0);  // sample 2 is taken before the first pulse, same inputs
    last_s = '0;
    last_c = '0;
    rst_n = 1'b1;
    clken = 1'b1;

    while (pulses < NSAMP && cyc < WD_LIMIT) begin
      @(posedge clk);
      clk_was_en = clken;
      if (clken) en_edges++;
      @(negedge clk);
      cyc++;

      if (!clk_was_en) check_int("R8", "out_valid after disabled edge", longint'(out_valid), 0);

      if (out_valid) begin
        pulses++;
        if (pulses == 1) check_int("R3", "enabled edges to first pulse", en_edges, 2 * MAG_W + 1);
        else check_int("R2", "enabled edges between pulses", en_edges - last_en, MAG_W);
        last_en = en_edges;
        if (sb.size() == 0) begin
          check_int("R2", "pulse without expected sample", 1, 0);
        end else begin
          e = sb.pop_front();
          check_near(e.tag, "R4 sine", int'(sine), e.es);
          check_near(e.tag, "R4 cosine", int'(cosine), e.ec);
        end
        check_int("R10", "sine most negative", longint'(sine == -16'sd32768), 0);
        check_int("R10", "cosine most negative", longint'(cosine == -16'sd32768), 0);
        last_s = sine;
        last_c = cosine;
        if (pulses < NSTIM) begin
          if (pulses >= 14 && pulses <= 18) begin
            // R7: junk on non-sampling cycles, restored before the sampling edge
            phase_inc = 32'hDEAD_BEEF;
            phase_mod = 16'hA5A5;
            pend_k    = pulses;
            junk_left = 2;
          end else begin
            drive(pulses);
          end
        end
      end else begin
        check_int("R11", "sine held between pulses", longint'(sine), longint'(last_s));
        check_int("R11", "cosine held between pulses", longint'(cosine), longint'(last_c));
        if (junk_left > 0) begin
          junk_left--;
          if (junk_left == 0) drive(pend_k);
        end
      end

      // R8: gated enable pattern during the later samples
      if (pulses >= 22 && pulses <= 32) clken = (cyc % 3 != 1);
      else clken = 1'b1;
    end

    if (cyc >= WD_LIMIT) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: pulses=%0d expected=%0d", pulses, NSAMP);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule